// File: doc/BRIEF.md
# Banked Scan Lookup Engine

This block answers "which stored entry equals this key?" without building a wide parallel comparator over a register array. Entries sit in several small synchronous RAM banks that all share one row address. A search walks a single row counter from the top row to the bottom, reading the same row from every bank on each step. Each bank compares the word it reads against a captured copy of the key. The first row that yields an equal, valid entry ends the search. So the time a search takes depends on the number of rows in one bank, and the number of banks does not add to it.

Software or a host engine loads entries through a single write port by naming a bank and a row and supplying the word and its valid flag. Searches are issued with a request pulse and a key. The block returns a one-cycle completion pulse, a hit flag and the index of the matching entry. The index is formed as {row, bank}, with the bank number in the low bits. The write port and the search request share one ready signal. That signal is high only while no search is in progress.

Top module: `scan_lookup_top`

## Requirements
- R1: After reset `done` and `hit` are 0 and `wrReady` is 1, and every entry is invalid, so a first search returns a miss only after all rows have been read.
- R2: When `wrEn` and `wrReady` are both 1 at a rising edge, the entry at bank `wrBank`, row `wrRow` takes `wrData` and the valid flag `wrValid`. Writing `wrValid`=0 removes the entry from later searches.
- R3: A search request is accepted only at an edge where `wrReady` is 1. A `srchReq` raised while a search runs is ignored and produces no later `done`.
- R4: `wrReady` is 0 from the edge that accepts a search until the edge that raises `done`. A write presented while `wrReady` is 0 changes no entry.
- R5: On a hit, `done` is 1 for exactly one cycle together with `hit`=1 and `matchIdx` = row*NUM_BANKS + bank, so the bank number occupies the low log2(NUM_BANKS) bits and the row occupies the bits above them.
- R6: Rows are scanned from 0 upward and the scan stops at the first row with a match. When several banks match in that row, the lowest bank number is reported.
- R7: An entry whose valid flag is 0 never matches, even if its stored word equals the key.
- R8: Counting from the accepting edge, `done` rises at edge r+2 for a hit in row r and at edge BANK_DEPTH+1 for a miss.
- R9: `hit` and `matchIdx` hold their values between `done` pulses.
- R10: A write and a search request presented in the same idle cycle are both accepted, and that search sees the newly written entry.
- R11: The key is captured at the accepting edge. Later changes on `srchKey` do not affect the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request for one entry |
| wrBank | input | log2(NUM_BANKS) | Target bank of the write |
| wrRow | input | log2(BANK_DEPTH) | Target row of the write |
| wrData | input | KEY_W | Word stored in the entry |
| wrValid | input | 1 | Valid flag stored with the entry |
| wrReady | output | 1 | High while idle; writes and search requests are taken only then |
| srchReq | input | 1 | Search request |
| srchKey | input | KEY_W | Key to look up, sampled when the request is taken |
| done | output | 1 | One-cycle pulse when a search finishes |
| hit | output | 1 | Result of the last search: 1 if an entry matched |
| matchIdx | output | log2(NUM_BANKS)+log2(BANK_DEPTH) | Index {row, bank} of the matching entry |

## Verification
Two pairs of functions can meet in the same cycle. The first is a load and a search start. This case is provoked by raising `wrEn` and `srchReq` in one idle cycle, with the written word equal to the key. It passes only if that search hits at the new entry with the row-based latency. The second is a load arriving while a scan is running. This case is provoked by holding `wrEn` high for two cycles and pulsing `srchReq` once in the middle of a miss scan. That scan must still end as a miss, no second `done` may follow, and a repeat search for the dropped word must also miss.

// File: rtl/scan_lookup_pkg.sv
package scan_lookup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } scanState_t;

  typedef struct packed {
    logic wrEn;   // commit one entry this cycle
    logic rdEn;   // read the current row from every bank
    logic keyLd;  // capture the search key
  } scanCtrl_t;

endpackage

// File: rtl/scan_bank.sv
module scan_bank #(
  parameter int KEY_W      = 64,
  parameter int BANK_DEPTH = 16,
  localparam int ROW_W     = $clog2(BANK_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [ROW_W-1:0] wrAddr,
  input  logic [KEY_W-1:0] wrData,
  input  logic             wrValid,
  input  logic             rdEn,
  input  logic [ROW_W-1:0] rdAddr,
  input  logic [KEY_W-1:0] key,
  output logic             match
);

  logic [KEY_W-1:0]      memWords [BANK_DEPTH];
  logic [BANK_DEPTH-1:0] validQ;
  logic [KEY_W-1:0]      rdDataQ;
  logic                  rdValidQ;

  // data array: plain synchronous RAM, no reset
  always_ff @(posedge clk) begin
    if (wrEn) memWords[wrAddr] <= wrData;
    if (rdEn) rdDataQ <= memWords[rdAddr];
  end

  // valid flags are cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= '0;
      rdValidQ <= 1'b0;
    end else begin
      if (wrEn) validQ[wrAddr] <= wrValid;
      if (rdEn) rdValidQ <= validQ[rdAddr];
    end
  end

  assign match = rdValidQ && (rdDataQ == key);

  // R4: the control must not commit writes while it is reading the banks
  assert_valid_frozen_in_scan_R4 : assert property (
    @(posedge clk) disable iff (!rstN)
      rdEn |=> $stable(validQ));

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_lookup_pkg::*;
#(
  parameter int KEY_W      = 64,
  parameter int NUM_BANKS  = 16,
  parameter int BANK_DEPTH = 16,
  localparam int ROW_W     = $clog2(BANK_DEPTH),
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanCtrl_t         ctrl,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic [KEY_W-1:0]  wrData,
  input  logic              wrValid,
  input  logic [KEY_W-1:0]  srchKey,
  output logic              anyHit,
  output logic [BANK_W-1:0] hitBank,
  output logic [ROW_W-1:0]  hitRow
);

  logic [KEY_W-1:0]     keyQ;
  logic                 cmpValid;
  logic [ROW_W-1:0]     cmpRow;
  logic [NUM_BANKS-1:0] matchVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ     <= '0;
      cmpValid <= 1'b0;
      cmpRow   <= '0;
    end else begin
      if (ctrl.keyLd) keyQ <= srchKey;
      cmpValid <= ctrl.rdEn;
      if (ctrl.rdEn) cmpRow <= rowAddr;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bankWr;
    assign bankWr = ctrl.wrEn && (wrBank == BANK_W'(b));
    scan_bank #(
      .KEY_W      (KEY_W),
      .BANK_DEPTH (BANK_DEPTH)
    ) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (bankWr),
      .wrAddr  (wrRow),
      .wrData  (wrData),
      .wrValid (wrValid),
      .rdEn    (ctrl.rdEn),
      .rdAddr  (rowAddr),
      .key     (keyQ),
      .match   (matchVec[b])
    );
  end

  // lowest bank wins: walk downward so the last assignment is the smallest
  always_comb begin
    hitBank = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (matchVec[b]) hitBank = BANK_W'(b);
    end
  end

  assign anyHit = cmpValid && (|matchVec);
  assign hitRow = cmpRow;

  // R6: reported bank matches and no lower bank matches
  assert_lowest_bank_R6 : assert property (
    @(posedge clk) disable iff (!rstN)
      anyHit |-> (matchVec[hitBank] &&
                  ((matchVec & ~({NUM_BANKS{1'b1}} << hitBank)) == '0)));

  // R11: the captured key only moves when a search is accepted
  assert_key_held_R11 : assert property (
    @(posedge clk) disable iff (!rstN)
      ctrl.rdEn |=> $stable(keyQ));

endmodule

// File: rtl/scan_control.sv
module scan_control
  import scan_lookup_pkg::*;
#(
  parameter int NUM_BANKS  = 16,
  parameter int BANK_DEPTH = 16,
  localparam int ROW_W     = $clog2(BANK_DEPTH),
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int IDX_W     = ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              srchReq,
  input  logic              anyHit,
  input  logic [BANK_W-1:0] hitBank,
  input  logic [ROW_W-1:0]  hitRow,
  output scanCtrl_t         ctrl,
  output logic [ROW_W-1:0]  rowAddr,
  output logic              wrReady,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  matchIdx
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(BANK_DEPTH - 1);

  scanState_t       state;
  logic [ROW_W-1:0] rowCnt;
  logic             isIdle;

  assign isIdle     = (state == ST_IDLE);
  assign wrReady    = isIdle;
  assign rowAddr    = rowCnt;
  assign ctrl.wrEn  = isIdle && wrEn;
  assign ctrl.keyLd = isIdle && srchReq;
  assign ctrl.rdEn  = (state == ST_SCAN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rowCnt   <= '0;
      done     <= 1'b0;
      hit      <= 1'b0;
      matchIdx <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (srchReq) begin
            state  <= ST_SCAN;
            rowCnt <= '0;
          end
        end
        ST_SCAN: begin
          if (anyHit) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            hit      <= 1'b1;
            matchIdx <= {hitRow, hitBank};
          end else if (rowCnt == LAST_ROW) begin
            state <= ST_DRAIN;
          end else begin
            rowCnt <= rowCnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          state <= ST_IDLE;
          done  <= 1'b1;
          hit   <= anyHit;
          if (anyHit) matchIdx <= {hitRow, hitBank};
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse
  assert_done_pulse_R5 : assert property (
    @(posedge clk) disable iff (!rstN)
      done |=> !done);

  // R1: a miss is only declared after the last row has been compared
  assert_miss_after_drain_R1 : assert property (
    @(posedge clk) disable iff (!rstN)
      (done && !hit) |-> ($past(state) == ST_DRAIN));

  // R3: an accepted request starts the scan at row 0
  assert_accept_starts_scan_R3 : assert property (
    @(posedge clk) disable iff (!rstN)
      (srchReq && isIdle) |=> (state == ST_SCAN && rowCnt == '0));

  // R9: results move only together with done
  assert_result_held_R9 : assert property (
    @(posedge clk) disable iff (!rstN)
      !done |-> ($stable(hit) && $stable(matchIdx)));

endmodule

// File: rtl/scan_lookup_top.sv
module scan_lookup_top
  import scan_lookup_pkg::*;
#(
  parameter int KEY_W      = 64,
  parameter int NUM_BANKS  = 16,
  parameter int BANK_DEPTH = 16,
  localparam int ROW_W     = $clog2(BANK_DEPTH),
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int IDX_W     = ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic [KEY_W-1:0]  wrData,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic              srchReq,
  input  logic [KEY_W-1:0]  srchKey,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  matchIdx
);

  scanCtrl_t         ctrl;
  logic [ROW_W-1:0]  rowAddr;
  logic              anyHit;
  logic [BANK_W-1:0] hitBank;
  logic [ROW_W-1:0]  hitRow;

  scan_control #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_DEPTH (BANK_DEPTH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .srchReq  (srchReq),
    .anyHit   (anyHit),
    .hitBank  (hitBank),
    .hitRow   (hitRow),
    .ctrl     (ctrl),
    .rowAddr  (rowAddr),
    .wrReady  (wrReady),
    .done     (done),
    .hit      (hit),
    .matchIdx (matchIdx)
  );

  scan_datapath #(
    .KEY_W      (KEY_W),
    .NUM_BANKS  (NUM_BANKS),
    .BANK_DEPTH (BANK_DEPTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .rowAddr (rowAddr),
    .wrBank  (wrBank),
    .wrRow   (wrRow),
    .wrData  (wrData),
    .wrValid (wrValid),
    .srchKey (srchKey),
    .anyHit  (anyHit),
    .hitBank (hitBank),
    .hitRow  (hitRow)
  );

endmodule

// File: tb/sim_scan_lookup_top.sv
`timescale 1ns/1ps
module sim_scan_lookup_top;

  localparam int KEY_W = 64;
  localparam int NB    = 16;
  localparam int BD    = 16;
  localparam int ROW_W = $clog2(BD);
  localparam int BNK_W = $clog2(NB);
  localparam int IDX_W = ROW_W + BNK_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [BNK_W-1:0]  wrBank = '0;
  logic [ROW_W-1:0]  wrRow = '0;
  logic [KEY_W-1:0]  wrData = '0;
  logic              wrValid = 1'b0;
  logic              wrReady;
  logic              srchReq = 1'b0;
  logic [KEY_W-1:0]  srchKey = '0;
  logic              done;
  logic              hit;
  logic [IDX_W-1:0]  matchIdx;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;  // 50 MHz

  scan_lookup_top #(.KEY_W(KEY_W), .NUM_BANKS(NB), .BANK_DEPTH(BD)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBank(wrBank), .wrRow(wrRow),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady), .srchReq(srchReq),
    .srchKey(srchKey), .done(done), .hit(hit), .matchIdx(matchIdx)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idxOf(input int row, input int bank);
    return row * NB + bank;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic writeEntry(input int bank, input int row, input logic [KEY_W-1:0] data, input bit vld);
    @(negedge clk);
    check(wrReady == 1'b1, "R2 ready before write", wrReady, 1);
    wrEn = 1'b1; wrBank = BNK_W'(bank); wrRow = ROW_W'(row); wrData = data; wrValid = vld;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Issue a search, optionally together with a write (R10) or with
  // interference during the scan (R3, R4); check result and latency.
  task automatic runSearch(input logic [KEY_W-1:0] key, input bit expHit, input int expIdx,
                           input int expLat, input string req, input bit sameCycleWr,
                           input bit meddle, input logic [KEY_W-1:0] meddleKey);
    int lat = 0;
    @(negedge clk);
    srchReq = 1'b1; srchKey = key;
    if (sameCycleWr) begin
      wrEn = 1'b1; wrBank = BNK_W'(7); wrRow = ROW_W'(9); wrData = key; wrValid = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    srchReq = 1'b0; wrEn = 1'b0;
    srchKey = ~key;  // R11: later key changes must not matter
    while (!done && lat < 100) begin
      if (meddle && lat == 2) begin
        check(wrReady == 1'b0, "R4 busy ready", wrReady, 0);
        wrEn = 1'b1; wrBank = BNK_W'(4); wrRow = ROW_W'(4); wrData = meddleKey; wrValid = 1'b1;
        srchReq = 1'b1; srchKey = meddleKey;
      end
      if (meddle && lat == 3) srchReq = 1'b0;
      if (meddle && lat == 4) wrEn = 1'b0;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    wrEn = 1'b0; srchReq = 1'b0;
    check(done == 1'b1, {req, " done seen"}, done, 1);
    check(lat == expLat, {req, " R8 latency"}, lat, expLat);
    check(hit == expHit, {req, " hit"}, hit, expHit);
    if (expHit) check(int'(matchIdx) == expIdx, {req, " R5 index"}, matchIdx, expIdx);
    @(negedge clk);
    check(done == 1'b0, "R5 done single cycle", done, 0);
    check(wrReady == 1'b1, "R4 ready after done", wrReady, 1);
  endtask

  task automatic testReset();
    check(done == 1'b0, "R1 reset done", done, 0);
    check(hit == 1'b0, "R1 reset hit", hit, 0);
    check(wrReady == 1'b1, "R1 reset ready", wrReady, 1);
    // R1/R7: every entry invalid, key 0 misses after full scan
    runSearch(64'h0, 1'b0, 0, BD + 1, "R1 first search", 1'b0, 1'b0, '0);
  endtask

  task automatic testBasicHit();
    writeEntry(5, 3, 64'hA5A5_0000_1234_5678, 1'b1);
    runSearch(64'hA5A5_0000_1234_5678, 1'b1, idxOf(3, 5), 3 + 2, "R2 basic hit", 1'b0, 1'b0, '0);
    repeat (5) @(negedge clk);
    check(hit == 1'b1 && int'(matchIdx) == idxOf(3, 5), "R9 result held", matchIdx, idxOf(3, 5));
  endtask

  task automatic testPriority();
    writeEntry(9, 3, 64'hBEEF, 1'b1);
    writeEntry(2, 3, 64'hBEEF, 1'b1);
    writeEntry(0, 7, 64'hBEEF, 1'b1);
    runSearch(64'hBEEF, 1'b1, idxOf(3, 2), 3 + 2, "R6 lowest bank in first row", 1'b0, 1'b0, '0);
  endtask

  task automatic testEdges();
    writeEntry(15, 0, 64'hC0C0, 1'b1);
    runSearch(64'hC0C0, 1'b1, idxOf(0, 15), 2, "R8 row 0", 1'b0, 1'b0, '0);
    writeEntry(0, BD - 1, 64'hD0D0, 1'b1);
    runSearch(64'hD0D0, 1'b1, idxOf(BD - 1, 0), BD + 1, "R8 last row", 1'b0, 1'b0, '0);
  endtask

  task automatic testInvalidate();
    writeEntry(5, 3, 64'hA5A5_0000_1234_5678, 1'b0);
    runSearch(64'hA5A5_0000_1234_5678, 1'b0, 0, BD + 1, "R7 invalidated entry", 1'b0, 1'b0, '0);
  endtask

  task automatic testSameCycle();
    runSearch(64'hE1E1_E1E1, 1'b1, idxOf(9, 7), 9 + 2, "R10 write with search", 1'b1, 1'b0, '0);
  endtask

  task automatic testBusy();
    int extra = 0;
    writeEntry(1, 1, 64'hF00D, 1'b1);
    // search an absent key while a write of it and a second request arrive
    runSearch(64'h6666, 1'b0, 0, BD + 1, "R3 busy scan", 1'b0, 1'b1, 64'h6666);
    repeat (20) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R3 request during scan ignored", extra, 0);
    runSearch(64'h6666, 1'b0, 0, BD + 1, "R4 write during scan dropped", 1'b0, 1'b0, '0);
    runSearch(64'hF00D, 1'b1, idxOf(1, 1), 1 + 2, "R2 entry still present", 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicHit();
    testPriority();
    testEdges();
    testInvalidate();
    testSameCycle();
    testBusy();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule